// File: doc/BRIEF.md
# Banked Memory Select Controller

This block produces the memory chip selects for an 8-bit CPU bus with a 16-bit address space. The lower 32 KB can be switched between four devices: a boot ROM, a lower RAM and two expansion RAMs. The upper 32 KB always maps to a fixed upper RAM. Software picks the lower-half device by writing to a bank-select I/O port. The two low data bits of that write go into a small register, and reset clears that register, so the system always starts from the boot ROM.

The port address is fixed at elaboration in steps of 8 bytes, from 00h up to 38h, with 38h as the default. Two static strap inputs are passed straight through as the top two ROM address lines. They choose one 16 KB window of a 64 KB ROM image. A typical boot flow runs from ROM, copies an operating system into upper RAM and jumps there. It then writes bank 1, which puts RAM in place of the ROM. After that, all 64 KB of the address space is RAM.

Top module: `banked_mem_select`

## Requirements
- R1: Reset (rst_n low) clears the bank register to 0 asynchronously. Until the first qualifying port write, lower-half memory accesses select the boot ROM.
- R2: A qualifying port write stores bus_data[1:0] as the new bank value. Data bits 7..2 have no effect on the resulting mapping.
- R3: The port decode compares bus_addr[7:3] with {2'b00, PORT_SLOT[2:0]} and ignores bus_addr[2:0]. A write to any other I/O address leaves the mapping unchanged.
- R4: A port write qualifies only when io_req_n and write_n are both low and opfetch_n is high. Qualifying inputs with opfetch_n low, with write_n high, or with io_req_n high change nothing.
- R5: For a memory request (mem_req_n low) with bus_addr[15]=0, exactly one lower-half select is driven low. Bank 0 drives boot_rom_cs_n, bank 1 drives low_ram_cs_n, bank 2 drives exp_a_cs_n and bank 3 drives exp_b_cs_n.
- R6: For a memory request with bus_addr[15]=1, only high_ram_cs_n is driven low, whatever the bank value.
- R7: While mem_req_n is low, exactly one of the five selects is low. While mem_req_n is high, all five are high, including during I/O cycles.
- R8: rom_a14 follows rom_window[0] and rom_a15 follows rom_window[1] at all times.
- R9: The bank register changes on the rising clock edge that ends the qualifying write. A memory access presented in that same cycle still uses the old bank value.
- R10: The port base is PORT_SLOT times 8, so PORT_SLOT=2 places the port at 10h. The default PORT_SLOT=7 places it at 38h.
- R11: A written bank value holds through any number of non-qualifying cycles, until reset or the next qualifying write.

Ports of the top module, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| bus_addr | input | 16 | CPU address bus; bits 7..0 carry the I/O port number |
| bus_data | input | 8 | CPU data bus during writes |
| mem_req_n | input | 1 | Active-low memory request |
| io_req_n | input | 1 | Active-low I/O request |
| write_n | input | 1 | Active-low write strobe |
| opfetch_n | input | 1 | Active-low opcode-fetch / interrupt-acknowledge marker |
| rom_window | input | 2 | Static ROM window strap |
| boot_rom_cs_n | output | 1 | Boot ROM select, active low |
| low_ram_cs_n | output | 1 | Lower RAM select, active low |
| exp_a_cs_n | output | 1 | Expansion RAM A select, active low |
| exp_b_cs_n | output | 1 | Expansion RAM B select, active low |
| high_ram_cs_n | output | 1 | Upper RAM select, active low |
| rom_a14 | output | 1 | ROM address line 14 |
| rom_a15 | output | 1 | ROM address line 15 |

## Verification
On every cycle, the bound assertions check four things. Exactly one select is low during a memory request and none is low otherwise. The upper half always selects upper RAM. The lower half follows the registered bank. The bank register loads only on an I/O write that matches the port, takes the data bits, and otherwise holds its value. Some behaviours appear only in the bench's scenarios, which compare against a behavioural model every clock: data bits 7..2 are ignored, near-miss port addresses are rejected, a different port slot works, the same-cycle memory access sees the old bank, and a reset in mid-run takes the mapping back to the ROM.

// File: rtl/bms_pkg.sv
package bms_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int IO_W      = 8;
  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int SLOT_LSB  = 3;
  localparam int SLOT_W    = IO_W - SLOT_LSB;

  typedef enum logic [BANK_W-1:0] {
    BANK_BOOT_ROM = 2'd0,
    BANK_LOW_RAM  = 2'd1,
    BANK_EXP_A    = 2'd2,
    BANK_EXP_B    = 2'd3
  } bank_e;

  // Port code for a slot: only slots 0..7 exist, so upper bits stay zero.
  function automatic logic [SLOT_W-1:0] slot_code(input int unsigned slot);
    logic [SLOT_W-1:0] c;
    c = '0;
    c[2:0] = slot[2:0];
    return c;
  endfunction

  // One-hot active-high decode of a bank value.
  function automatic logic [NUM_BANKS-1:0] bank_onehot(input logic [BANK_W-1:0] b);
    logic [NUM_BANKS-1:0] v;
    v = '0;
    v[b] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/bms_io_decode.sv
module bms_io_decode
  import bms_pkg::*;
#(
  parameter int unsigned PORT_SLOT = 7
) (
  input  logic [IO_W-1:0] io_addr,
  input  logic            io_req_n,
  input  logic            write_n,
  input  logic            opfetch_n,
  output logic            port_hit,
  output logic            bank_load
);
  localparam logic [SLOT_W-1:0] SLOT_CODE = slot_code(PORT_SLOT);

  logic io_write;

  always_comb begin
    port_hit  = (io_addr[IO_W-1:SLOT_LSB] == SLOT_CODE);
    io_write  = !io_req_n && !write_n && opfetch_n;
    bank_load = port_hit && io_write;
  end
endmodule

// File: rtl/bms_bank_reg.sv
module bms_bank_reg
  import bms_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] d,
  output bank_e             q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= BANK_BOOT_ROM;
    else if (load) q <= bank_e'(d);
  end
endmodule

// File: rtl/bms_cs_gen.sv
module bms_cs_gen
  import bms_pkg::*;
(
  input  logic                 mem_req_n,
  input  logic                 upper_half,
  input  bank_e                bank,
  output logic [NUM_BANKS-1:0] low_cs_n,
  output logic                 high_cs_n
);
  logic [NUM_BANKS-1:0] bank_sel;
  logic                 low_access;

  always_comb begin
    bank_sel   = bank_onehot(bank);
    low_access = !mem_req_n && !upper_half;
    high_cs_n  = !(!mem_req_n && upper_half);
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_low
    assign low_cs_n[i] = !(low_access && bank_sel[i]);
  end
endmodule

// File: rtl/banked_mem_select.sv
module banked_mem_select
  import bms_pkg::*;
#(
  parameter int unsigned PORT_SLOT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              mem_req_n,
  input  logic              io_req_n,
  input  logic              write_n,
  input  logic              opfetch_n,
  input  logic [1:0]        rom_window,
  output logic              boot_rom_cs_n,
  output logic              low_ram_cs_n,
  output logic              exp_a_cs_n,
  output logic              exp_b_cs_n,
  output logic              high_ram_cs_n,
  output logic              rom_a14,
  output logic              rom_a15
);
  logic                 port_hit;
  logic                 bank_load;
  bank_e                bank_q;
  logic [NUM_BANKS-1:0] low_cs_n;
  logic                 unused_bits;

  assign unused_bits = ^{bus_addr[ADDR_W-2:IO_W], bus_data[DATA_W-1:BANK_W]};

  bms_io_decode #(.PORT_SLOT(PORT_SLOT)) u_dec (
    .io_addr   (bus_addr[IO_W-1:0]),
    .io_req_n  (io_req_n),
    .write_n   (write_n),
    .opfetch_n (opfetch_n),
    .port_hit  (port_hit),
    .bank_load (bank_load)
  );

  bms_bank_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (bank_load),
    .d     (bus_data[BANK_W-1:0]),
    .q     (bank_q)
  );

  bms_cs_gen u_cs (
    .mem_req_n  (mem_req_n),
    .upper_half (bus_addr[ADDR_W-1]),
    .bank       (bank_q),
    .low_cs_n   (low_cs_n),
    .high_cs_n  (high_ram_cs_n)
  );

  assign boot_rom_cs_n = low_cs_n[BANK_BOOT_ROM];
  assign low_ram_cs_n  = low_cs_n[BANK_LOW_RAM];
  assign exp_a_cs_n    = low_cs_n[BANK_EXP_A];
  assign exp_b_cs_n    = low_cs_n[BANK_EXP_B];
  assign rom_a14       = rom_window[0];
  assign rom_a15       = rom_window[1];
endmodule

// File: rtl/bms_chk.sv
module bms_chk
  import bms_pkg::*;
#(
  parameter int unsigned PORT_SLOT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              mem_req_n,
  input logic              io_req_n,
  input logic              write_n,
  input logic              opfetch_n,
  input logic              bank_load,
  input logic [BANK_W-1:0] bank_q,
  input logic [NUM_BANKS-1:0] low_cs_n,
  input logic              high_ram_cs_n
);
  logic [NUM_BANKS:0] all_cs_n;
  assign all_cs_n = {high_ram_cs_n, low_cs_n};

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load |=> bank_q == $past(bus_data[BANK_W-1:0]));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_load |=> $stable(bank_q));

  p_qualify_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load |-> (!io_req_n && !write_n && opfetch_n));

  p_port_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load |-> bus_addr[IO_W-1:SLOT_LSB] == slot_code(PORT_SLOT));

  p_one_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req_n |-> $countones(~all_cs_n) == 1);

  p_idle_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_n |-> &all_cs_n);

  p_upper_ram_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && bus_addr[ADDR_W-1]) |-> !high_ram_cs_n);

  p_lower_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && !bus_addr[ADDR_W-1]) |-> ~low_cs_n == bank_onehot(bank_q));
endmodule

bind banked_mem_select bms_chk #(.PORT_SLOT(PORT_SLOT)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_data      (bus_data),
  .mem_req_n     (mem_req_n),
  .io_req_n      (io_req_n),
  .write_n       (write_n),
  .opfetch_n     (opfetch_n),
  .bank_load     (bank_load),
  .bank_q        (bank_q),
  .low_cs_n      (low_cs_n),
  .high_ram_cs_n (high_ram_cs_n)
);

// File: tb/banked_mem_select_tb_top.sv
module banked_mem_select_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_data = 8'h00;
  logic        mem_req_n = 1'b1;
  logic        io_req_n = 1'b1;
  logic        write_n = 1'b1;
  logic        opfetch_n = 1'b1;
  logic [1:0]  rom_window = 2'b00;

  logic [6:0] out_a, out_b;
  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 0;

  int model_a = 0;  // bank for port at 38h
  int model_b = 0;  // bank for port at 10h

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_mem_select dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .mem_req_n(mem_req_n), .io_req_n(io_req_n), .write_n(write_n),
    .opfetch_n(opfetch_n), .rom_window(rom_window),
    .boot_rom_cs_n(out_a[6]), .low_ram_cs_n(out_a[5]), .exp_a_cs_n(out_a[4]),
    .exp_b_cs_n(out_a[3]), .high_ram_cs_n(out_a[2]),
    .rom_a15(out_a[1]), .rom_a14(out_a[0])
  );

  banked_mem_select #(.PORT_SLOT(2)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .mem_req_n(mem_req_n), .io_req_n(io_req_n), .write_n(write_n),
    .opfetch_n(opfetch_n), .rom_window(rom_window),
    .boot_rom_cs_n(out_b[6]), .low_ram_cs_n(out_b[5]), .exp_a_cs_n(out_b[4]),
    .exp_b_cs_n(out_b[3]), .high_ram_cs_n(out_b[2]),
    .rom_a15(out_b[1]), .rom_a14(out_b[0])
  );

  // Reference model: bank value per port, updated at the clock edge that
  // ends a qualifying write (R9), cleared asynchronously by reset (R1).
  function automatic bit write_to(int port);
    return !io_req_n && !write_n && opfetch_n &&
           (int'(bus_addr[7:0]) / 8 == port / 8);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_a = 0;
      model_b = 0;
    end else begin
      if (write_to(8'h38)) model_a = int'(bus_data) % 4;
      if (write_to(8'h10)) model_b = int'(bus_data) % 4;
    end
  end

  function automatic logic [6:0] expect_out(int bank);
    logic [6:0] e;
    e = 7'b1111100;
    e[1] = rom_window[1];
    e[0] = rom_window[0];
    if (!mem_req_n) begin
      if (bus_addr >= 16'h8000) e[2] = 1'b0;
      else e[6 - bank] = 1'b0;
    end
    return e;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [6:0] ea, eb;
      ea = expect_out(model_a);
      eb = expect_out(model_b);
      checks += 2;
      if (out_a !== ea) begin
        fails++;
        $display("FAIL %s port38 addr=%h got=%b exp=%b", cur_req, bus_addr, out_a, ea);
      end
      if (out_b !== eb) begin
        fails++;
        $display("FAIL %s port10 addr=%h got=%b exp=%b", cur_req, bus_addr, out_b, eb);
      end
    end
  end

  task automatic bus_cycle(input logic mreq, input logic ioreq, input logic wr,
                           input logic m1, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    #1;
    mem_req_n = mreq; io_req_n = ioreq; write_n = wr; opfetch_n = m1;
    bus_addr = a; bus_data = d;
  endtask

  task automatic mem_rd(input logic [15:0] a);
    bus_cycle(1'b0, 1'b1, 1'b1, 1'b1, a, 8'h00);
  endtask

  task automatic io_wr(input logic [7:0] port, input logic [7:0] d);
    bus_cycle(1'b1, 1'b0, 1'b0, 1'b1, {8'h00, port}, d);
  endtask

  task automatic probe_all();
    mem_rd(16'h0000); mem_rd(16'h1234); mem_rd(16'h7FFF);
    mem_rd(16'h8000); mem_rd(16'hFFFF);
    bus_cycle(1'b1, 1'b1, 1'b1, 1'b1, 16'h0100, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state selects boot ROM in lower half
    cur_req = "R1";
    mem_rd(16'h0000); mem_rd(16'h4000);
    bus_cycle(1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 8'h00);
    @(negedge clk); #1; rst_n = 1'b1;
    probe_all();

    // R8: ROM window straps
    cur_req = "R8";
    for (int w = 0; w < 4; w++) begin
      @(negedge clk); #1; rom_window = 2'(w);
      mem_rd(16'h0010);
    end

    // R5 / R6: every bank, lower and upper half
    for (int b = 0; b < 4; b++) begin
      cur_req = "R5";
      io_wr(8'h38, 8'(b));
      io_wr(8'h10, 8'(3 - b));
      probe_all();
      cur_req = "R6";
      mem_rd(16'hC000);
    end

    // R2: upper data bits ignored
    cur_req = "R2";
    io_wr(8'h38, 8'hFE); probe_all();
    io_wr(8'h38, 8'hFD); probe_all();

    // R3: A2..A0 ignored, near misses rejected
    cur_req = "R3";
    io_wr(8'h3F, 8'h03); probe_all();
    io_wr(8'h78, 8'h00); probe_all();
    io_wr(8'h40, 8'h00); probe_all();
    io_wr(8'h30, 8'h00); probe_all();

    // R10: second instance responds at 10h only
    cur_req = "R10";
    io_wr(8'h17, 8'h01); probe_all();
    io_wr(8'h18, 8'h02); probe_all();

    // R4: non-qualifying strobes
    cur_req = "R4";
    bus_cycle(1'b1, 1'b0, 1'b0, 1'b0, 16'h0038, 8'h02); probe_all();
    bus_cycle(1'b1, 1'b0, 1'b1, 1'b1, 16'h0038, 8'h02); probe_all();
    bus_cycle(1'b0, 1'b1, 1'b0, 1'b1, 16'h0038, 8'h02); probe_all();

    // R9: memory access in the same cycle as the write sees old bank
    cur_req = "R9";
    io_wr(8'h38, 8'h00); mem_rd(16'h0000);
    bus_cycle(1'b0, 1'b0, 1'b0, 1'b1, 16'h0038, 8'h01);
    mem_rd(16'h0038);
    bus_cycle(1'b0, 1'b0, 1'b0, 1'b1, 16'h0038, 8'h02);
    mem_rd(16'h0038);

    // R7: idle and I/O cycles drive no select
    cur_req = "R7";
    bus_cycle(1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 8'h00);
    bus_cycle(1'b1, 1'b0, 1'b1, 1'b1, 16'h8080, 8'h00);
    bus_cycle(1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 8'h00);

    // R11: mapping holds across many unrelated cycles
    cur_req = "R11";
    io_wr(8'h38, 8'h03);
    for (int i = 0; i < 50; i++) begin
      mem_rd(16'(i * 700));
      bus_cycle(1'b1, 1'b0, 1'b0, 1'b1, 16'(8'h40 + i), 8'h00);
    end
    probe_all();

    // R1: asynchronous reset mid-run returns to boot ROM
    cur_req = "R1";
    mem_rd(16'h0200);
    #2; rst_n = 1'b0;
    @(negedge clk); #1; rst_n = 1'b1;
    probe_all();

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule